// File: doc/BRIEF.md
# Feature-Gated Instruction Legality Checker

This block sits beside the decode stage of a small 32-bit RISC core. For every instruction word that the fetch stage presents, it decides whether the instruction may run. Otherwise it raises exactly one trap request: illegal instruction, break or system call. Some instruction classes exist only when an optional hardware unit was built into the core: multiplier, divider, barrel shifter or sign extender. For those classes the decision follows a feature mask input. A core without a barrel shifter can still shift right by one position, so right shifts are judged by their shift amount. For the register form that amount is only known at execution time, and it arrives on a separate input.

Control-register writes that target a debug breakpoint or watchpoint slot the core does not have are also rejected. The limit is set by two count inputs. Each trap request is a one-cycle pulse, registered one clock after the instruction is accepted. It comes with a writeback-kill pulse and a latched trap PC. The trap PC is always word aligned, because the fetch address has its two low bits cleared and a misaligned PC never traps by itself. The mapping from opcode to instruction class is set by parameters.

Top module: `insn_gate`

## Requirements
- R1: While reset is held and in the first cycle after it, trap_illegal, trap_break, trap_syscall, wb_kill and trap_pc are all zero.
- R2: Opcode field insn[31:26]. Unsigned divide (0x04) and unsigned modulo (0x05) are illegal when feat_en bit 1 (divider) is 0, and legal when it is 1.
- R3: Multiply in register form (0x06) and immediate form (0x03) is illegal when feat_en bit 0 (multiplier) is 0, and legal when it is 1.
- R4: Sign-extend byte (0x0A) and sign-extend halfword (0x0B) are illegal when feat_en bit 3 (sign extender) is 0, and legal when it is 1.
- R5: Shift-left in immediate form (0x02) and register form (0x09) is illegal when feat_en bit 2 (barrel shifter) is 0, and legal when it is 1.
- R6: The immediate right shifts (arithmetic 0x01, logical 0x00) are always legal when feat_en bit 2 is 1. When it is 0, they are legal only if the imm5 field insn[4:0] equals 1.
- R7: The register right shifts (arithmetic 0x07, logical 0x08) are always legal when feat_en bit 2 is 1. When it is 0, they are legal only if shift_src[4:0] equals 1. The higher bits of shift_src have no effect.
- R8: In the system opcode group (0x0C), imm5 = 2 gives a break request, imm5 = 7 gives a system-call request, and every other imm5 value gives an illegal-instruction request.
- R9: The user-defined opcode 0x0D is always illegal, as are the unassigned opcodes 0x0F and 0x30 to 0x3F. Every other opcode outside R2 to R8 and R10 is legal whatever the feature mask.
- R10: A control-register write (0x0E) with select insn[25:21] equal to 0x10+n (breakpoint slot n) is illegal when n >= bp_count. With select 0x18+n (watchpoint slot n), it is illegal when n >= wp_count. Other selects are legal.
- R11: A trap request appears one clock after the edge that samples insn_valid = 1. It lasts one cycle, is never raised for insn_valid = 0, and is never raised together with another. Priority is illegal > break > system call. wb_kill pulses with every trap.
- R12: On each trap, trap_pc captures insn_pc with bits 1:0 cleared. A misaligned insn_pc is not trapped for that reason. trap_pc keeps its value until the next trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Instruction word is valid this cycle |
| insn | input | 32 | Instruction word |
| insn_pc | input | XLEN | Fetch PC of the instruction |
| shift_src | input | XLEN | Run-time value of the shift-amount source register |
| feat_en | input | 4 | Feature mask: bit0 multiplier, bit1 divider, bit2 barrel shifter, bit3 sign extender |
| bp_count | input | CNT_W | Number of breakpoint slots implemented |
| wp_count | input | CNT_W | Number of watchpoint slots implemented |
| trap_illegal | output | 1 | Illegal-instruction trap pulse |
| trap_break | output | 1 | Break trap pulse |
| trap_syscall | output | 1 | System-call trap pulse |
| wb_kill | output | 1 | Suppress writeback of the trapped instruction |
| trap_pc | output | XLEN | Word-aligned PC of the last trapped instruction |

## Verification
Every result is due exactly one clock after the edge that samples the instruction. This covers the three trap pulses, wb_kill and the update of trap_pc. The bench applies each stimulus on a falling edge. It compares all outputs at the next falling edge against a behavioural model, so every comparison falls one full clock after its stimulus. Each stimulus occupies one clock, so back-to-back instructions are also checked for pulses that must drop after one cycle.

// File: rtl/insn_gate_pkg.sv
`timescale 1ns/1ps
package insn_gate_pkg;

    localparam int FEAT_W     = 4;
    localparam int FEAT_MUL   = 0;
    localparam int FEAT_DIV   = 1;
    localparam int FEAT_SHIFT = 2;
    localparam int FEAT_SEXT  = 3;

    localparam int SYS_BREAK  = 2;
    localparam int SYS_CALL   = 7;

    typedef enum logic [3:0] {
        CLS_PLAIN,
        CLS_MUL,
        CLS_DIV,
        CLS_SEXT,
        CLS_SHL,
        CLS_SHR_I,
        CLS_SHR_R,
        CLS_SYS,
        CLS_USER,
        CLS_CSRW,
        CLS_UNDEF
    } insn_cls_e;

    typedef struct packed {
        logic ill;
        logic brk;
        logic sc;
    } trap_req_t;

endpackage

// File: rtl/insn_gate_classify.sv
`timescale 1ns/1ps
module insn_gate_classify
    import insn_gate_pkg::*;
#(
    parameter logic [5:0]  OP_SRU_I    = 6'h00,
    parameter logic [5:0]  OP_SR_I     = 6'h01,
    parameter logic [5:0]  OP_SL_I     = 6'h02,
    parameter logic [5:0]  OP_MUL_I    = 6'h03,
    parameter logic [5:0]  OP_DIVU     = 6'h04,
    parameter logic [5:0]  OP_MODU     = 6'h05,
    parameter logic [5:0]  OP_MUL_R    = 6'h06,
    parameter logic [5:0]  OP_SR_R     = 6'h07,
    parameter logic [5:0]  OP_SRU_R    = 6'h08,
    parameter logic [5:0]  OP_SL_R     = 6'h09,
    parameter logic [5:0]  OP_SEXTB    = 6'h0A,
    parameter logic [5:0]  OP_SEXTH    = 6'h0B,
    parameter logic [5:0]  OP_SYS      = 6'h0C,
    parameter logic [5:0]  OP_USER     = 6'h0D,
    parameter logic [5:0]  OP_CSRW     = 6'h0E,
    parameter logic [63:0] OPC_DEFINED = 64'h0000_FFFF_FFFF_7FFF
) (
    input  logic [5:0] opcode,
    output insn_cls_e  cls
);

    always_comb begin
        case (opcode)
            OP_MUL_I, OP_MUL_R:  cls = CLS_MUL;
            OP_DIVU, OP_MODU:    cls = CLS_DIV;
            OP_SEXTB, OP_SEXTH:  cls = CLS_SEXT;
            OP_SL_I, OP_SL_R:    cls = CLS_SHL;
            OP_SR_I, OP_SRU_I:   cls = CLS_SHR_I;
            OP_SR_R, OP_SRU_R:   cls = CLS_SHR_R;
            OP_SYS:              cls = CLS_SYS;
            OP_USER:             cls = CLS_USER;
            OP_CSRW:             cls = CLS_CSRW;
            default:             cls = OPC_DEFINED[opcode] ? CLS_PLAIN : CLS_UNDEF;
        endcase
    end

endmodule

// File: rtl/insn_gate_slots.sv
`timescale 1ns/1ps
module insn_gate_slots #(
    parameter int NUM_SLOTS = 4,
    parameter int SEL_W     = 5,
    parameter int CNT_W     = 3,
    parameter int BP_BASE   = 'h10,
    parameter int WP_BASE   = 'h18
) (
    input  logic [SEL_W-1:0] csr_sel,
    input  logic [CNT_W-1:0] bp_cnt,
    input  logic [CNT_W-1:0] wp_cnt,
    output logic             slot_bad
);

    logic [NUM_SLOTS-1:0] bp_bad;
    logic [NUM_SLOTS-1:0] wp_bad;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        localparam logic [SEL_W-1:0] BP_SEL = SEL_W'(BP_BASE + i);
        localparam logic [SEL_W-1:0] WP_SEL = SEL_W'(WP_BASE + i);
        // slot i exists only when the configured count exceeds i
        assign bp_bad[i] = (csr_sel == BP_SEL) && (bp_cnt <= CNT_W'(i));
        assign wp_bad[i] = (csr_sel == WP_SEL) && (wp_cnt <= CNT_W'(i));
    end

    assign slot_bad = (|bp_bad) | (|wp_bad);

endmodule

// File: rtl/insn_gate_rules.sv
`timescale 1ns/1ps
module insn_gate_rules
    import insn_gate_pkg::*;
(
    input  insn_cls_e         cls,
    input  logic [FEAT_W-1:0] feat,
    input  logic [4:0]        imm5,
    input  logic [4:0]        shamt5,
    input  logic              slot_bad,
    output trap_req_t         req
);

    always_comb begin
        req = '0;
        case (cls)
            CLS_MUL:   req.ill = !feat[FEAT_MUL];
            CLS_DIV:   req.ill = !feat[FEAT_DIV];
            CLS_SEXT:  req.ill = !feat[FEAT_SEXT];
            CLS_SHL:   req.ill = !feat[FEAT_SHIFT];
            // without the barrel shifter only a single-position right shift exists
            CLS_SHR_I: req.ill = !feat[FEAT_SHIFT] && (imm5 != 5'd1);
            CLS_SHR_R: req.ill = !feat[FEAT_SHIFT] && (shamt5 != 5'd1);
            CLS_SYS: begin
                if (imm5 == 5'(SYS_BREAK))     req.brk = 1'b1;
                else if (imm5 == 5'(SYS_CALL)) req.sc  = 1'b1;
                else                           req.ill = 1'b1;
            end
            CLS_USER:  req.ill = 1'b1;
            CLS_UNDEF: req.ill = 1'b1;
            CLS_CSRW:  req.ill = slot_bad;
            default:   req = '0;
        endcase
    end

endmodule

// File: rtl/insn_gate.sv
`timescale 1ns/1ps
module insn_gate
    import insn_gate_pkg::*;
#(
    parameter int          XLEN        = 32,
    parameter int          NUM_SLOTS   = 4,
    parameter int          CSR_BP_BASE = 'h10,
    parameter int          CSR_WP_BASE = 'h18,
    parameter logic [5:0]  OP_SYS      = 6'h0C,
    parameter logic [5:0]  OP_USER     = 6'h0D,
    parameter logic [63:0] OPC_DEFINED = 64'h0000_FFFF_FFFF_7FFF,
    localparam int         CNT_W       = $clog2(NUM_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_valid,
    input  logic [31:0]       insn,
    input  logic [XLEN-1:0]   insn_pc,
    input  logic [XLEN-1:0]   shift_src,
    input  logic [FEAT_W-1:0] feat_en,
    input  logic [CNT_W-1:0]  bp_count,
    input  logic [CNT_W-1:0]  wp_count,
    output logic              trap_illegal,
    output logic              trap_break,
    output logic              trap_syscall,
    output logic              wb_kill,
    output logic [XLEN-1:0]   trap_pc
);

    typedef struct packed {
        logic            ill;
        logic            brk;
        logic            sc;
        logic            kill;
        logic [XLEN-1:0] pc;
    } gate_state_t;

    logic [5:0] opcode;
    logic [4:0] imm5;
    logic [4:0] csr_sel;
    insn_cls_e  cls;
    logic       slot_bad;
    trap_req_t  req;
    logic       unused_bits;

    assign opcode      = insn[31:26];
    assign csr_sel     = insn[25:21];
    assign imm5        = insn[4:0];
    assign unused_bits = ^{insn[20:5], insn_pc[1:0], shift_src[XLEN-1:5]};

    insn_gate_classify #(
        .OP_SYS      (OP_SYS),
        .OP_USER     (OP_USER),
        .OPC_DEFINED (OPC_DEFINED)
    ) u_classify (
        .opcode (opcode),
        .cls    (cls)
    );

    insn_gate_slots #(
        .NUM_SLOTS (NUM_SLOTS),
        .SEL_W     (5),
        .CNT_W     (CNT_W),
        .BP_BASE   (CSR_BP_BASE),
        .WP_BASE   (CSR_WP_BASE)
    ) u_slots (
        .csr_sel  (csr_sel),
        .bp_cnt   (bp_count),
        .wp_cnt   (wp_count),
        .slot_bad (slot_bad)
    );

    insn_gate_rules u_rules (
        .cls      (cls),
        .feat     (feat_en),
        .imm5     (imm5),
        .shamt5   (shift_src[4:0]),
        .slot_bad (slot_bad),
        .req      (req)
    );

    gate_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.ill  = 1'b0;
        st_d.brk  = 1'b0;
        st_d.sc   = 1'b0;
        st_d.kill = 1'b0;
        if (insn_valid) begin
            st_d.ill  = req.ill;
            st_d.brk  = !req.ill && req.brk;
            st_d.sc   = !req.ill && !req.brk && req.sc;
            st_d.kill = req.ill | req.brk | req.sc;
            if (st_d.kill) begin
                st_d.pc = {insn_pc[XLEN-1:2], 2'b00};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trap_illegal = st_q.ill;
    assign trap_break   = st_q.brk;
    assign trap_syscall = st_q.sc;
    assign wb_kill      = st_q.kill;
    assign trap_pc      = st_q.pc;

    assert_one_trap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({trap_illegal, trap_break, trap_syscall}));

    assert_trap_needs_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_illegal || trap_break || trap_syscall) |-> $past(insn_valid));

    assert_pc_aligned_R12: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pc[1:0] == 2'b00);

    assert_pc_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_kill |-> $stable(trap_pc));

    assert_user_illegal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && insn[31:26] == OP_USER) |=> trap_illegal);

    assert_syscall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && insn[31:26] == OP_SYS && insn[4:0] == 5'(SYS_CALL)) |=> trap_syscall);

endmodule

// File: tb/insn_gate_tb.sv
`timescale 1ns/1ps
module insn_gate_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic [31:0] insn = '0;
    logic [31:0] insn_pc = '0;
    logic [31:0] shift_src = '0;
    logic [3:0]  feat_en = '0;
    logic [2:0]  bp_count = '0;
    logic [2:0]  wp_count = '0;
    logic        trap_illegal, trap_break, trap_syscall, wb_kill;
    logic [31:0] trap_pc;

    int errors = 0;
    int checks = 0;
    logic [31:0] exp_pc = '0;
    int pc_seq = 0;

    always #2.5 clk = ~clk;

    insn_gate u_dut (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
        .insn_pc(insn_pc), .shift_src(shift_src), .feat_en(feat_en),
        .bp_count(bp_count), .wp_count(wp_count),
        .trap_illegal(trap_illegal), .trap_break(trap_break),
        .trap_syscall(trap_syscall), .wb_kill(wb_kill), .trap_pc(trap_pc)
    );

    // 0 none, 1 illegal, 2 break, 3 system call
    function automatic int ref_eval(logic [31:0] w, logic [31:0] sh, logic [3:0] f, int bpc, int wpc);
        int op  = int'(w[31:26]);
        int im  = int'(w[4:0]);
        int sel = int'(w[25:21]);
        if (op == 4 || op == 5)   return f[1] ? 0 : 1;
        if (op == 3 || op == 6)   return f[0] ? 0 : 1;
        if (op == 10 || op == 11) return f[3] ? 0 : 1;
        if (op == 2 || op == 9)   return f[2] ? 0 : 1;
        if (op == 0 || op == 1)   return (f[2] || im == 1) ? 0 : 1;
        if (op == 7 || op == 8)   return (f[2] || sh[4:0] == 5'd1) ? 0 : 1;
        if (op == 12) begin
            if (im == 2) return 2;
            if (im == 7) return 3;
            return 1;
        end
        if (op == 13) return 1;
        if (op == 14) begin
            if (sel >= 16 && sel < 20) return (sel - 16 >= bpc) ? 1 : 0;
            if (sel >= 24 && sel < 28) return (sel - 24 >= wpc) ? 1 : 0;
            return 0;
        end
        if (op == 15 || op >= 48) return 1;
        return 0;
    endfunction

    function automatic string tag_of(int op);
        if (op == 4 || op == 5)   return "R2";
        if (op == 3 || op == 6)   return "R3";
        if (op == 10 || op == 11) return "R4";
        if (op == 2 || op == 9)   return "R5";
        if (op == 0 || op == 1)   return "R6";
        if (op == 7 || op == 8)   return "R7";
        if (op == 12)             return "R8";
        if (op == 14)             return "R10";
        return "R9";
    endfunction

    function automatic logic [31:0] mk(int op, int sel, int im);
        return {6'(op), 5'(sel), 16'h5A5A, 5'(im)};
    endfunction

    // called at a falling edge; result compared at the next falling edge
    task automatic step(bit v, logic [31:0] w, logic [31:0] sh, logic [3:0] f,
                        int bpc, int wpc, string tag);
        int e;
        logic [4:0] exp_vec, act_vec;
        logic [31:0] p;
        p = 32'h0000_4000 + 32'(pc_seq * 4) + 32'(pc_seq % 4);
        pc_seq++;
        insn_valid = v; insn = w; shift_src = sh; feat_en = f;
        bp_count = 3'(bpc); wp_count = 3'(wpc); insn_pc = p;
        e = v ? ref_eval(w, sh, f, bpc, wpc) : 0;
        if (e != 0) exp_pc = {p[31:2], 2'b00};
        exp_vec = {e == 1, e == 2, e == 3, e != 0, 1'b0};
        @(negedge clk);
        act_vec = {trap_illegal, trap_break, trap_syscall, wb_kill, 1'b0};
        checks++;
        if (act_vec != exp_vec || trap_pc !== exp_pc) begin
            errors++;
            $display("FAIL %s: insn=%h feat=%b act traps=%b pc=%h exp traps=%b pc=%h",
                     tag, w, f, act_vec[4:1], trap_pc, exp_vec[4:1], exp_pc);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: act=timeout exp=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values while held
        checks++;
        if ({trap_illegal, trap_break, trap_syscall, wb_kill} != 4'b0 || trap_pc != 32'h0) begin
            errors++;
            $display("FAIL R1: act=%b/%h exp=0000/0", {trap_illegal, trap_break, trap_syscall, wb_kill}, trap_pc);
        end
        rst_n = 1'b1;
        step(1'b0, mk(13, 0, 0), 32'h0, 4'h0, 0, 0, "R1");

        // R2..R7, R9: every feature mask over a directed opcode set
        for (int f = 0; f < 16; f++) begin
            int ops[20] = '{4, 5, 3, 6, 10, 11, 2, 9, 13, 15, 48, 63, 16, 33, 47, 12, 14, 0, 1, 7};
            int amts[5] = '{0, 1, 2, 31, 33};
            foreach (ops[k]) step(1'b1, mk(ops[k], 3, 1), 32'h0, 4'(f), 4, 4, tag_of(ops[k]));
            foreach (amts[k]) begin
                step(1'b1, mk(0, 0, amts[k] % 32), 32'hFFFF_FFFF, 4'(f), 4, 4, "R6");
                step(1'b1, mk(1, 0, amts[k] % 32), 32'h1, 4'(f), 4, 4, "R6");
                step(1'b1, mk(7, 0, 1), 32'(amts[k]), 4'(f), 4, 4, "R7");
                step(1'b1, mk(8, 0, 5), 32'(amts[k]) | 32'hABC0_0000, 4'(f), 4, 4, "R7");
            end
        end

        // R8: whole system group
        for (int im = 0; im < 32; im++) step(1'b1, mk(12, 0, im), 32'h0, 4'hF, 4, 4, "R8");

        // R10: debug slot writes against every count
        for (int c = 0; c <= 4; c++)
            for (int sel = 0; sel < 32; sel++)
                step(1'b1, mk(14, sel, 0), 32'h0, 4'hF, c, 4 - c, "R10");

        // R11: invalid words never trap; back-to-back traps each last one cycle
        step(1'b0, mk(13, 0, 0), 32'h0, 4'h0, 0, 0, "R11");
        step(1'b0, mk(12, 0, 7), 32'h0, 4'h0, 0, 0, "R11");
        step(1'b1, mk(12, 0, 2), 32'h0, 4'h0, 0, 0, "R11");
        step(1'b1, mk(12, 0, 7), 32'h0, 4'h0, 0, 0, "R11");
        step(1'b1, mk(13, 0, 0), 32'h0, 4'h0, 0, 0, "R11");
        step(1'b1, mk(20, 0, 0), 32'h0, 4'h0, 0, 0, "R11");

        // R12: misaligned PCs, hold across legal words
        for (int k = 0; k < 8; k++) step(1'b1, mk(k % 2 ? 13 : 20, 0, 0), 32'h0, 4'h0, 0, 0, "R12");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule